// File: doc/BRIEF.md
# Two-Level Interrupt Cause Controller

This block gathers 64 level-sensitive interrupt sources into two 32-bit cause words, low and high. Each word has a CPU mask word beside it. A single registered interrupt line goes to the CPU while any enabled cause bit is pending. Four summary inputs from a separate pin interrupt unit are merged into the high cause word. Software reads and clears cause bits and programs masks over a plain 32-bit register bus.

To locate a source quickly, software reads one select register. It returns the masked low word while anything enabled is pending there. Otherwise it returns the masked high word, and a flag bit in the returned value tells the two cases apart. One read plus a find-first-set then names the interrupting source.

Top module: `irqc_top`

## Requirements
- R1: After reset both cause words and both mask words read 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: Source input i (0..31) sets low cause bit i, and source i (32..63) sets high cause bit i-32, one clock after it is seen. The cause words read at offset 0x004 (low) and 0x00C (high) whatever the masks hold.
- R3: A cause bit stays set while its source is high. A write to the cause word cannot clear it during that time.
- R4: A cause bit stays set after its source falls. Writing a cause word clears exactly the bits written as 0 whose source is low, and keeps the bits written as 1.
- R5: The mask words are read and written at 0x014 (low) and 0x01C (high). A 1 enables the matching cause bit and a 0 blocks it.
- R6: `irq_o` is 1 exactly one clock after the OR over both words of (cause AND mask) is 1, and falls the same way.
- R7: A read of 0x024 behaves as follows. If (low cause AND low mask) is nonzero, it returns that value with bit 30 forced to 0. Otherwise it returns (high cause AND high mask) with bit 30 forced to 1.
- R8: Input `pin_grp_i[g]` (g = 0..3) sets high cause bit 24+g, ORed with source 56+g.
- R9: Reads of any other offset return 0, and writes to them change no register.
- R10: Read data appears on `bus_rdata_o` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Raw level interrupt sources |
| pin_grp_i | input | 4 | Summary inputs from the pin interrupt unit |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered CPU interrupt line |

## Verification
The bench builds the block with its default parameters: 32-bit words, the pin group at high bits 24..27 and the select flag at bit 30. With these values, low source 30 collides with the select flag, so the forced-zero flag rule is observable. The pin group also overlaps sources 56..59, which exercises the OR merge. Both halves of the select decision are reached, and so is the empty case, where only the flag is returned.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_CAUSE_LO = 32'h004;
  localparam int unsigned OFF_CAUSE_HI = 32'h00C;
  localparam int unsigned OFF_MASK_LO  = 32'h014;
  localparam int unsigned OFF_MASK_HI  = 32'h01C;
  localparam int unsigned OFF_SELECT   = 32'h024;

  typedef enum logic [2:0] {
    RS_NONE, RS_CAUSE_LO, RS_CAUSE_HI, RS_MASK_LO, RS_MASK_HI, RS_SELECT
  } reg_sel_e;
endpackage

// File: rtl/irqc_cause_word.sv
module irqc_cause_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         cause_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend
);
  logic [W-1:0] keep;

  // written 0 drops a latched bit, written 1 keeps it; live sources always win
  always_comb begin
    keep = cause_we ? (cause_q & wdata) : cause_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= src | keep;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pend = cause_q & mask_q;
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int W        = 32,
  parameter int FLAG_BIT = 30
) (
  input  logic [W-1:0] pend_lo,
  input  logic [W-1:0] pend_hi,
  output logic [W-1:0] sel_val
);
  always_comb begin
    if (|pend_lo) begin
      sel_val           = pend_lo;
      sel_val[FLAG_BIT] = 1'b0;
    end else begin
      sel_val           = pend_hi;
      sel_val[FLAG_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_regbus.sv
module irqc_regbus
  import irqc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [W-1:0]  cause_lo,
  input  logic [W-1:0]  cause_hi,
  input  logic [W-1:0]  mask_lo,
  input  logic [W-1:0]  mask_hi,
  input  logic [W-1:0]  sel_val,
  output logic [1:0]    cause_we,
  output logic [1:0]    mask_we,
  output logic [W-1:0]  rdata
);
  reg_sel_e     hit;
  logic [W-1:0] rd_mux;

  always_comb begin
    if      (addr == AW'(OFF_CAUSE_LO)) hit = RS_CAUSE_LO;
    else if (addr == AW'(OFF_CAUSE_HI)) hit = RS_CAUSE_HI;
    else if (addr == AW'(OFF_MASK_LO))  hit = RS_MASK_LO;
    else if (addr == AW'(OFF_MASK_HI))  hit = RS_MASK_HI;
    else if (addr == AW'(OFF_SELECT))   hit = RS_SELECT;
    else                                hit = RS_NONE;
  end

  assign cause_we = {wr && (hit == RS_CAUSE_HI), wr && (hit == RS_CAUSE_LO)};
  assign mask_we  = {wr && (hit == RS_MASK_HI),  wr && (hit == RS_MASK_LO)};

  always_comb begin
    case (hit)
      RS_CAUSE_LO: rd_mux = cause_lo;
      RS_CAUSE_HI: rd_mux = cause_hi;
      RS_MASK_LO:  rd_mux = mask_lo;
      RS_MASK_HI:  rd_mux = mask_hi;
      RS_SELECT:   rd_mux = sel_val;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int DW       = 32,
  parameter int AW       = 12,
  parameter int PIN_N    = 4,
  parameter int PIN_LSB  = 24,
  parameter int SEL_FLAG = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*DW-1:0] src_i,
  input  logic [PIN_N-1:0] pin_grp_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_wr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  input  logic            bus_rd_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_o
);
  localparam int NW = 2;

  logic [2*DW-1:0] pin_vec;
  logic [2*DW-1:0] src_eff;
  logic [2*DW-1:0] cause_all;
  logic [2*DW-1:0] mask_all;
  logic [2*DW-1:0] pend_all;
  logic [NW-1:0]   cause_we;
  logic [NW-1:0]   mask_we;
  logic [DW-1:0]   sel_val;
  logic            irq_q;
  logic            mask_we_any;

  // pin-unit summaries land in the high word
  always_comb begin
    pin_vec = '0;
    for (int g = 0; g < PIN_N; g++) pin_vec[DW + PIN_LSB + g] = pin_grp_i[g];
  end
  assign src_eff = src_i | pin_vec;

  for (genvar w = 0; w < NW; w++) begin : g_word
    irqc_cause_word #(.W(DW)) u_word (
      .clk      (clk),
      .rst      (rst),
      .src      (src_eff[w*DW +: DW]),
      .cause_we (cause_we[w]),
      .mask_we  (mask_we[w]),
      .wdata    (bus_wdata_i),
      .cause_q  (cause_all[w*DW +: DW]),
      .mask_q   (mask_all[w*DW +: DW]),
      .pend     (pend_all[w*DW +: DW])
    );
  end

  irqc_select #(.W(DW), .FLAG_BIT(SEL_FLAG)) u_sel (
    .pend_lo (pend_all[DW-1:0]),
    .pend_hi (pend_all[2*DW-1:DW]),
    .sel_val (sel_val)
  );

  irqc_regbus #(.W(DW), .AW(AW)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr_i),
    .wr       (bus_wr_i),
    .rd       (bus_rd_i),
    .cause_lo (cause_all[DW-1:0]),
    .cause_hi (cause_all[2*DW-1:DW]),
    .mask_lo  (mask_all[DW-1:0]),
    .mask_hi  (mask_all[2*DW-1:DW]),
    .sel_val  (sel_val),
    .cause_we (cause_we),
    .mask_we  (mask_we),
    .rdata    (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_all;
  end

  assign irq_o       = irq_q;
  assign mask_we_any = |mask_we;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2*DW-1:0] src_all,
  input logic [2*DW-1:0] cause_all,
  input logic [2*DW-1:0] mask_all,
  input logic            mask_we_any,
  input logic            irq_o
);
  // R1: line is quiet right after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_o);

  // R2 / R3: every high source is reflected as a set cause bit
  a_r2_src_sets: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cause_all & $past(src_all)) == $past(src_all)));

  // R4: a cause bit never rises without a source
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cause_all & ~$past(cause_all) & ~$past(src_all)) == '0));

  // R5: masks move only on a mask write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mask_we_any)) |-> $stable(mask_all));

  // R6: line follows enabled pending bits one clock later
  a_r6_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(cause_all & mask_all))));
endmodule

bind irqc_top irqc_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_all     (src_eff),
  .cause_all   (cause_all),
  .mask_all    (mask_all),
  .mask_we_any (mask_we_any),
  .irq_o       (irq_o)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [3:0]  pin = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst(rst), .src_i(src), .pin_grp_i(pin),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rd_i(rd), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wreg(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rdata", rdata, 0);
    rreg(12'h014, v); chk("R1 mask lo", v, 0);
    rreg(12'h01C, v); chk("R1 mask hi", v, 0);
    rreg(12'h004, v); chk("R1 cause lo", v, 0);
  endtask

  task automatic t_src_map();
    logic [31:0] v;
    @(negedge clk); src[5] = 1'b1; src[40] = 1'b1;
    idle(1);
    rreg(12'h004, v); chk("R2 low word", v, 32'h20);
    rreg(12'h00C, v); chk("R2 high word", v, 32'h100);
    idle(2);
    chk("R6 masked off", {31'b0, irq}, 0);
    @(negedge clk); src[40] = 1'b0;
    wreg(12'h00C, 0);
    rreg(12'h00C, v); chk("R4 clear high", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wreg(12'h004, 0);
    rreg(12'h004, v); chk("R3 held by source", v, 32'h20);
    @(negedge clk); src[5] = 1'b0;
    idle(2);
    rreg(12'h004, v); chk("R4 sticky", v, 32'h20);
    @(negedge clk); src[1] = 1'b1; src[2] = 1'b1;
    @(negedge clk); src[1] = 1'b0; src[2] = 1'b0;
    wreg(12'h004, 32'hFFFF_FFDD);
    rreg(12'h004, v); chk("R4 partial clear", v, 32'h4);
    wreg(12'h004, 0);
    rreg(12'h004, v); chk("R4 full clear", v, 0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    wreg(12'h014, 32'h4);
    rreg(12'h014, v); chk("R5 mask lo", v, 32'h4);
    wreg(12'h01C, 32'h8000_0001);
    rreg(12'h01C, v); chk("R5 mask hi", v, 32'h8000_0001);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); src[3] = 1'b0;
    idle(2);
    chk("R6 blocked bit", {31'b0, irq}, 0);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); src[2] = 1'b0;
    // cause set at first edge, line at second
    chk("R6 not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 raised", {31'b0, irq}, 1);
    wreg(12'h014, 0);
    chk("R6 still high", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R6 dropped", {31'b0, irq}, 0);
    @(negedge clk); src[63] = 1'b1;
    @(negedge clk); src[63] = 1'b0;
    @(negedge clk);
    chk("R6 high word", {31'b0, irq}, 1);
    wreg(12'h00C, 0); wreg(12'h004, 0); wreg(12'h01C, 0);
    idle(2);
    chk("R6 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    rreg(12'h024, v); chk("R7 empty", v, 32'h4000_0000);
    @(negedge clk); src[3] = 1'b1; src[39] = 1'b1;
    @(negedge clk); src[3] = 1'b0; src[39] = 1'b0;
    wreg(12'h014, 32'h8); wreg(12'h01C, 32'h80);
    rreg(12'h024, v); chk("R7 low wins", v, 32'h8);
    wreg(12'h014, 0);
    rreg(12'h024, v); chk("R7 high flagged", v, 32'h4000_0080);
    wreg(12'h004, 0); wreg(12'h00C, 0); wreg(12'h01C, 0);
    @(negedge clk); src[30] = 1'b1;
    @(negedge clk); src[30] = 1'b0;
    wreg(12'h014, 32'h4000_0000);
    rreg(12'h024, v); chk("R7 low flag forced 0", v, 0);
    wreg(12'h014, 0); wreg(12'h004, 0);
  endtask

  task automatic t_pin();
    logic [31:0] v;
    @(negedge clk); pin = 4'b0101;
    @(negedge clk); pin = 4'b0000;
    rreg(12'h00C, v); chk("R8 pin group", v, 32'h0500_0000);
    wreg(12'h00C, 0);
    rreg(12'h00C, v); chk("R8 cleared", v, 0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    wreg(12'h014, 32'h1234_5678);
    wreg(12'h000, 32'hFFFF_FFFF);
    wreg(12'h008, 32'hFFFF_FFFF);
    wreg(12'h010, 32'hFFFF_FFFF);
    wreg(12'h028, 32'hFFFF_FFFF);
    rreg(12'h014, v); chk("R9 mask lo untouched", v, 32'h1234_5678);
    rreg(12'h01C, v); chk("R9 mask hi untouched", v, 0);
    rreg(12'h004, v); chk("R9 cause untouched", v, 0);
    rreg(12'h010, v); chk("R9 unused read", v, 0);
    idle(3);
    chk("R10 hold", rdata, 0);
    rreg(12'h014, v);
    idle(2);
    chk("R10 hold value", rdata, 32'h1234_5678);
    wreg(12'h014, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_src_map();
    t_level();
    t_mask_irq();
    t_select();
    t_pin();
    t_unused();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule